// File: doc/BRIEF.md
# Host Bridge Configuration Registers with Upper-Memory Shadow Steering

This block holds the 256-byte configuration space of a host-to-PCI bridge. Any byte can be read through a byte-addressed register port. Writes reach only the command/status bytes and the device-specific area. Reset loads the identity bytes, class bytes and default command bytes.

Two device-specific bytes control the shadowing of the upper-memory region (0xC0000 to 0xFFFFF). That region is split into eight 32 KB windows:
- One byte is a per-window enable mask.
- The other byte holds a two-bit steering mode that all enabled windows share.

For the memory address on its input, the block reports combinationally whether a read, and separately a write, should go to internal DRAM or out to the external bus. A flag tells the rest of the chip when any of the four top windows (the BIOS area) are shadowed. A bus master-reset pulse turns that BIOS shadowing off and leaves the lower four enables as they are.

Top module: `bridge_cfg_space`

## Requirements
- R1: After the synchronous reset every byte reads zero except these: offset 0x00=0x39, 0x01=0x10, 0x02=0x96, 0x03=0x04, 0x04=0x07, 0x06=0x80, 0x07=0x02, 0x08=0x02, 0x0B=0x06.
- R2: A write (`cfg_we` high at a rising edge) to offset 0x04..0x07 or 0x40..0xFF stores `cfg_wdata`. `cfg_rdata` always shows the byte at `cfg_addr` combinationally.
- R3: Writes to offsets 0x00..0x03 and 0x08..0x3F are ignored, and those bytes keep their reset values.
- R4: When `mem_addr[31:18]` is not 0x3, which means outside 0xC0000..0xFFFFF, both `mem_rd_int` and `mem_wr_int` are 1.
- R5: Inside the region, window n is selected by `mem_addr[17:15]` and starts at 0xC0000 + n*0x8000. If bit n of offset 0x44 is 0, both outputs are 0 (external).
- R6: For an enabled window, bits [1:0] of offset 0x45 set the steering (1 = internal). Mode 0 gives rd=0, wr=1. Mode 1 gives rd=0, wr=0. Mode 2 gives rd=1, wr=1. Mode 3 gives rd=1, wr=0.
- R7: `shadow_bios` is 1 exactly when any of bits [7:4] of offset 0x44 is 1.
- R8: A `bus_mreset` cycle clears bits [7:4] of offset 0x44 and keeps bits [3:0]. Every other byte keeps its value, and a register write in the same cycle is ignored.
- R9: A write to offset 0x44 or 0x45 changes the steering outputs and `shadow_bios` from the cycle after the write edge, not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_mreset | input | 1 | Bus master-reset pulse, one cycle per event |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_we | input | 1 | Write strobe |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for `cfg_addr` |
| mem_addr | input | 32 | Memory address to classify |
| mem_rd_int | output | 1 | 1: a read at `mem_addr` goes to internal DRAM |
| mem_wr_int | output | 1 | 1: a write at `mem_addr` goes to internal DRAM |
| shadow_bios | output | 1 | BIOS-area shadowing is active |

## Verification
The assertions check on every cycle:
- the steering for out-of-region addresses and for disabled windows;
- the all-external mode;
- that read-only bytes never leave their reset values;
- that writable bytes take the written data;
- that a master-reset pulse clears the upper enables, keeps the lower ones and drops the BIOS flag.

Only the bench's scenarios can show the rest:
- the full set of reset values;
- the per-window mapping of all four mode encodings;
- the one-cycle delay between a write and the steering change;
- that a write landing in the master-reset cycle is lost.

// File: rtl/bcfg_pkg.sv
package bcfg_pkg;

    parameter int CFG_AW   = 8;
    parameter int CFG_DW   = 8;
    parameter int CFG_SIZE = 1 << CFG_AW;
    parameter int MEM_AW   = 32;
    parameter int SEG_CNT  = 8;
    parameter int SEG_SHIFT = 15;
    localparam int SEG_IW   = $clog2(SEG_CNT);
    localparam int TAG_LSB  = SEG_SHIFT + SEG_IW;
    localparam logic [MEM_AW-TAG_LSB-1:0] REGION_TAG = 'h3;

    localparam logic [CFG_AW-1:0] OFS_SHADOW_EN   = 8'h44;
    localparam logic [CFG_AW-1:0] OFS_SHADOW_MODE = 8'h45;

    typedef enum logic [1:0] {
        SM_RDEXT_WRINT = 2'd0,
        SM_ALL_EXT     = 2'd1,
        SM_ALL_INT     = 2'd2,
        SM_RDINT_WREXT = 2'd3
    } steer_mode_e;

    typedef struct packed {
        logic rd_int;
        logic wr_int;
    } steer_t;

    function automatic steer_t mode_steer(steer_mode_e m);
        steer_t s;
        case (m)
            SM_RDEXT_WRINT: s = '{rd_int: 1'b0, wr_int: 1'b1};
            SM_ALL_EXT:     s = '{rd_int: 1'b0, wr_int: 1'b0};
            SM_ALL_INT:     s = '{rd_int: 1'b1, wr_int: 1'b1};
            default:        s = '{rd_int: 1'b1, wr_int: 1'b0};
        endcase
        return s;
    endfunction

    function automatic logic [CFG_DW-1:0] cfg_reset_value(logic [CFG_AW-1:0] a);
        case (a)
            8'h00:   return 8'h39;
            8'h01:   return 8'h10;
            8'h02:   return 8'h96;
            8'h03:   return 8'h04;
            8'h04:   return 8'h07;
            8'h06:   return 8'h80;
            8'h07:   return 8'h02;
            8'h08:   return 8'h02;
            8'h0B:   return 8'h06;
            default: return '0;
        endcase
    endfunction

    function automatic logic cfg_writable(logic [CFG_AW-1:0] a);
        return (a >= 8'h04 && a <= 8'h07) || (a >= 8'h40);
    endfunction

endpackage

// File: rtl/bcfg_regfile.sv
module bcfg_regfile
    import bcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_mreset,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic              cfg_we,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic [CFG_DW-1:0] cfg_rdata,
    output logic [SEG_CNT-1:0] shadow_en,
    output steer_mode_e       shadow_mode
);

    logic [CFG_DW-1:0] regs [CFG_SIZE];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CFG_SIZE; i++) begin
                regs[i] <= cfg_reset_value(CFG_AW'(i));
            end
        end else if (bus_mreset) begin
            // Master reset: drop the BIOS-area enables, keep the low enables.
            regs[OFS_SHADOW_EN] <= {4'h0, regs[OFS_SHADOW_EN][3:0]};
        end else if (cfg_we && cfg_writable(cfg_addr)) begin
            regs[cfg_addr] <= cfg_wdata;
        end
    end

    assign cfg_rdata   = regs[cfg_addr];
    assign shadow_en   = regs[OFS_SHADOW_EN][SEG_CNT-1:0];
    assign shadow_mode = steer_mode_e'(regs[OFS_SHADOW_MODE][1:0]);

    AST_WRITE_STORES: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !bus_mreset && cfg_writable(cfg_addr))
        |=> (regs[$past(cfg_addr)] == $past(cfg_wdata)));  // R2

    AST_RO_HELD: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_writable(cfg_addr))
        |=> (regs[$past(cfg_addr)] == cfg_reset_value($past(cfg_addr))));  // R3

    AST_MRESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        bus_mreset |=> (regs[OFS_SHADOW_EN][7:4] == 4'h0));  // R8

    AST_MRESET_KEEPS: assert property (@(posedge clk) disable iff (rst)
        bus_mreset |=> (regs[OFS_SHADOW_EN][3:0] == $past(regs[OFS_SHADOW_EN][3:0])));  // R8

endmodule

// File: rtl/bcfg_shadow_decode.sv
module bcfg_shadow_decode
    import bcfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [SEG_CNT-1:0] shadow_en,
    input  steer_mode_e        shadow_mode,
    input  logic [MEM_AW-1:0]  mem_addr,
    output logic               mem_rd_int,
    output logic               mem_wr_int,
    output logic               shadow_bios
);

    localparam int BIOS_LO = SEG_CNT / 2;

    steer_t            mode_s;
    steer_t            seg_s [SEG_CNT];
    logic              in_region;
    logic [SEG_IW-1:0] seg_idx;
    steer_t            out_s;

    assign mode_s    = mode_steer(shadow_mode);
    assign in_region = (mem_addr[MEM_AW-1:TAG_LSB] == REGION_TAG);
    assign seg_idx   = mem_addr[TAG_LSB-1:SEG_SHIFT];

    for (genvar g = 0; g < SEG_CNT; g++) begin : g_seg
        // A disabled window steers both directions to the external bus.
        assign seg_s[g] = shadow_en[g] ? mode_s : '{rd_int: 1'b0, wr_int: 1'b0};
    end

    always_comb begin
        if (in_region) out_s = seg_s[seg_idx];
        else           out_s = '{rd_int: 1'b1, wr_int: 1'b1};
    end

    assign mem_rd_int  = out_s.rd_int;
    assign mem_wr_int  = out_s.wr_int;
    assign shadow_bios = |shadow_en[SEG_CNT-1:BIOS_LO];

    AST_OUTSIDE_INTERNAL: assert property (@(posedge clk) disable iff (rst)
        (mem_addr[MEM_AW-1:TAG_LSB] != REGION_TAG) |-> (mem_rd_int && mem_wr_int));  // R4

    AST_DISABLED_EXTERNAL: assert property (@(posedge clk) disable iff (rst)
        ((mem_addr[MEM_AW-1:TAG_LSB] == REGION_TAG) && !shadow_en[mem_addr[TAG_LSB-1:SEG_SHIFT]])
        |-> (!mem_rd_int && !mem_wr_int));  // R5

    AST_MODE_ALL_EXT: assert property (@(posedge clk) disable iff (rst)
        ((mem_addr[MEM_AW-1:TAG_LSB] == REGION_TAG) && shadow_en[mem_addr[TAG_LSB-1:SEG_SHIFT]]
         && (shadow_mode == SM_ALL_EXT)) |-> (!mem_rd_int && !mem_wr_int));  // R6

endmodule

// File: rtl/bridge_cfg_space.sv
module bridge_cfg_space
    import bcfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_mreset,
    input  logic [7:0]  cfg_addr,
    input  logic        cfg_we,
    input  logic [7:0]  cfg_wdata,
    output logic [7:0]  cfg_rdata,
    input  logic [31:0] mem_addr,
    output logic        mem_rd_int,
    output logic        mem_wr_int,
    output logic        shadow_bios
);

    logic [SEG_CNT-1:0] shadow_en;
    steer_mode_e        shadow_mode;

    bcfg_regfile u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_mreset  (bus_mreset),
        .cfg_addr    (cfg_addr),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .shadow_en   (shadow_en),
        .shadow_mode (shadow_mode)
    );

    bcfg_shadow_decode u_dec (
        .clk         (clk),
        .rst         (rst),
        .shadow_en   (shadow_en),
        .shadow_mode (shadow_mode),
        .mem_addr    (mem_addr),
        .mem_rd_int  (mem_rd_int),
        .mem_wr_int  (mem_wr_int),
        .shadow_bios (shadow_bios)
    );

    AST_BIOS_OFF_AFTER_MRESET: assert property (@(posedge clk) disable iff (rst)
        bus_mreset |=> !shadow_bios);  // R8

endmodule

// File: tb/sim_bridge_cfg_space.sv
`timescale 1ns/1ps
module sim_bridge_cfg_space;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_mreset = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [31:0] mem_addr = '0;
    logic        mem_rd_int;
    logic        mem_wr_int;
    logic        shadow_bios;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bridge_cfg_space u0 (
        .clk(clk), .rst(rst), .bus_mreset(bus_mreset),
        .cfg_addr(cfg_addr), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .mem_addr(mem_addr),
        .mem_rd_int(mem_rd_int), .mem_wr_int(mem_wr_int),
        .shadow_bios(shadow_bios)
    );

    typedef struct packed {
        logic [7:0] en;
        logic [1:0] mode;
        logic [2:0] seg;
        logic       rd;
        logic       wr;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{en: 8'h01, mode: 2'd0, seg: 3'd0, rd: 1'b0, wr: 1'b1},
        '{en: 8'h01, mode: 2'd0, seg: 3'd1, rd: 1'b0, wr: 1'b0},
        '{en: 8'h80, mode: 2'd2, seg: 3'd7, rd: 1'b1, wr: 1'b1},
        '{en: 8'h80, mode: 2'd3, seg: 3'd7, rd: 1'b1, wr: 1'b0},
        '{en: 8'h7E, mode: 2'd1, seg: 3'd3, rd: 1'b0, wr: 1'b0},
        '{en: 8'h7E, mode: 2'd2, seg: 3'd0, rd: 1'b0, wr: 1'b0},
        '{en: 8'hFF, mode: 2'd3, seg: 3'd4, rd: 1'b1, wr: 1'b0},
        '{en: 8'hFF, mode: 2'd0, seg: 3'd5, rd: 1'b0, wr: 1'b1}
    };

    function automatic logic [7:0] exp_reset(int a);
        case (a)
            0: return 8'h39;  1: return 8'h10;  2: return 8'h96;  3: return 8'h04;
            4: return 8'h07;  6: return 8'h80;  7: return 8'h02;  8: return 8'h02;
            11: return 8'h06;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [1:0] exp_mode(int m);
        // {rd_int, wr_int}
        case (m)
            0: return 2'b01;
            1: return 2'b00;
            2: return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    function automatic logic [31:0] seg_addr(int s, int ofs);
        return 32'h000C_0000 + 32'(s) * 32'h8000 + 32'(ofs);
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [7:0] a, logic [7:0] exp);
        cfg_addr = a;
        #1;
        chk(req, $sformatf("byte %02h", a), 32'(cfg_rdata), 32'(exp));
    endtask

    task automatic steer_chk(string req, logic [31:0] a, logic [1:0] exp);
        mem_addr = a;
        #1;
        chk(req, $sformatf("steer @%08h", a), {30'd0, mem_rd_int, mem_wr_int}, {30'd0, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual not finished, expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset contents of every byte
        for (int a = 0; a < 256; a++) rd_chk("R1", 8'(a), exp_reset(a));
        chk("R7", "bios after reset", 32'(shadow_bios), 32'd0);
        steer_chk("R5", seg_addr(0, 0), 2'b00);

        // Table walk: R5/R6 mixed enable masks
        for (int i = 0; i < 8; i++) begin
            wr(8'h44, VEC[i].en);
            wr(8'h45, {6'd0, VEC[i].mode});
            steer_chk(VEC[i].rd == VEC[i].wr && !VEC[i].rd ? "R5/R6" : "R6",
                      seg_addr(int'(VEC[i].seg), 16'h1234), {VEC[i].rd, VEC[i].wr});
        end

        // R6: all modes on every window, neighbour disabled (R5)
        for (int m = 0; m < 4; m++) begin
            wr(8'h45, 8'(m));
            for (int s = 0; s < 8; s++) begin
                wr(8'h44, 8'(1 << s));
                steer_chk("R6", seg_addr(s, 0), exp_mode(m));
                steer_chk("R6", seg_addr(s, 16'h7FFF), exp_mode(m));
                steer_chk("R5", seg_addr((s + 1) % 8, 0), 2'b00);
            end
        end

        // R4: outside the region is internal both ways
        steer_chk("R4", 32'h000B_FFFF, 2'b11);
        steer_chk("R4", 32'h0010_0000, 2'b11);
        steer_chk("R4", 32'h400C_0000, 2'b11);

        // R2: writable bytes
        wr(8'h04, 8'hA5); rd_chk("R2", 8'h04, 8'hA5);
        wr(8'h07, 8'h3C); rd_chk("R2", 8'h07, 8'h3C);
        wr(8'h40, 8'h5A); rd_chk("R2", 8'h40, 8'h5A);
        wr(8'hFF, 8'hC3); rd_chk("R2", 8'hFF, 8'hC3);

        // R3: read-only bytes ignore writes
        wr(8'h00, 8'hFF); rd_chk("R3", 8'h00, 8'h39);
        wr(8'h03, 8'hFF); rd_chk("R3", 8'h03, 8'h04);
        wr(8'h08, 8'hFF); rd_chk("R3", 8'h08, 8'h02);
        wr(8'h0B, 8'h00); rd_chk("R3", 8'h0B, 8'h06);
        wr(8'h3F, 8'hFF); rd_chk("R3", 8'h3F, 8'h00);

        // R7: BIOS flag follows bits [7:4] of 0x44
        wr(8'h44, 8'h0F); chk("R7", "bios low-only", 32'(shadow_bios), 32'd0);
        wr(8'h44, 8'h10); chk("R7", "bios bit4", 32'(shadow_bios), 32'd1);
        wr(8'h44, 8'h80); chk("R7", "bios bit7", 32'(shadow_bios), 32'd1);

        // R9: steering changes only after the write edge
        wr(8'h45, 8'h02);
        wr(8'h44, 8'h00);
        mem_addr = seg_addr(2, 0);
        @(negedge clk);
        cfg_addr = 8'h44; cfg_wdata = 8'h04; cfg_we = 1'b1;
        #1;
        chk("R9", "before edge", {30'd0, mem_rd_int, mem_wr_int}, 32'd0);
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        chk("R9", "after edge", {30'd0, mem_rd_int, mem_wr_int}, 32'd3);

        // R8: master reset keeps low enables, clears BIOS enables
        wr(8'h44, 8'hA5);
        wr(8'h45, 8'h03);
        @(negedge clk);
        bus_mreset = 1'b1;
        cfg_addr = 8'h50; cfg_wdata = 8'h77; cfg_we = 1'b1;
        @(negedge clk);
        bus_mreset = 1'b0; cfg_we = 1'b0;
        rd_chk("R8", 8'h44, 8'h05);
        rd_chk("R8", 8'h45, 8'h03);
        rd_chk("R8", 8'h50, 8'h00);
        rd_chk("R8", 8'h40, 8'h5A);
        chk("R8", "bios after mreset", 32'(shadow_bios), 32'd0);
        steer_chk("R8", seg_addr(0, 0), 2'b10);
        steer_chk("R8", seg_addr(5, 0), 2'b00);

        // R1: reset again restores defaults
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd_chk("R1", 8'h04, 8'h07);
        rd_chk("R1", 8'h44, 8'h00);
        rd_chk("R1", 8'hFF, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule